// File: doc/BRIEF.md
# Newton-Raphson significand divider

This unit divides one binary64 significand by another over several clock cycles and returns a quotient that is exact in every bit it delivers, together with a sticky flag that tells whether anything was left over. Each 53-bit operand carries its leading bit explicitly and may arrive with leading zeros, as a subnormal does. The unit first shifts each operand left until its top bit is set. It then reads a reciprocal seed for the divisor from a small computed table and sharpens that seed with Newton-Raphson steps, all at 56 fraction bits. Every intermediate product is truncated, so the reciprocal can only err low. A multiply by the dividend gives a provisional quotient, and a remainder test then raises it by one unit where needed.

A parent floating-point unit pulses `start` with two significands and waits for `done`. It then takes the quotient, the sticky flag, the two normalization shift counts and the halving flag, and uses them for exponent arithmetic and final rounding. Those steps are outside this unit. A single-precision quotient is obtained by rounding this double-precision result. Exponents, zero, infinity and NaN operands, and exception flags are also handled outside.

Top module: `nr_sig_div`

## Requirements
- R1: `start` high while `busy` is low is accepted at that clock edge. `busy` is high from the next cycle. `done` is high for exactly one cycle, 5 + 2×NR_STEPS cycles (11 by default) after the accepting edge, and `busy` is low in that same cycle.
- R2: `start` and any change of `a_sig`/`b_sig` while `busy` is high have no effect on the division in flight, neither on its result nor on its timing.
- R3: when `done` is high, `a_lz` and `b_lz` give the number of left shifts that brought the most significant set bit of each operand to bit 52.
- R4: when `done` is high, `q_adj` is 1 exactly when the normalized dividend is smaller than the normalized divisor. In that case the dividend was doubled before the divide, so the quotient exponent must be lowered by one.
- R5: when `done` is high, `quo` equals floor(A′·2^53 / B′), where B′ is the normalized divisor and A′ is the normalized dividend, doubled when `q_adj` is 1. The quotient lies in [1,2), so bit 53 of `quo` is always 1, bits 52..1 are the significand fraction and bit 0 is a round bit. `quo` holds its value in every cycle where `done` is low.
- R6: when `done` is high, `sticky` is 1 exactly when A′·2^53 − `quo`·B′ is nonzero.
- R7: a divisor whose 53 bits are all ones, the slowest case for the reciprocal, still yields the exact quotient and sticky.
- R8: equal nonzero operands give `quo` = 2^53 (exactly 1.0), `sticky` = 0 and `q_adj` = 0.
- R9: the provisional remainder A′·2^53 − R·B′ formed before correction is never negative, so the correction only ever adds one.
- R10: a `start` in the cycle where `done` is high is accepted. The finishing result is still presented intact in that cycle, and the new division completes with the normal latency.
- R11: after reset, `busy`, `done`, `quo` and `sticky` are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a division when idle |
| a_sig | input | 53 | Dividend significand, leading bit explicit, nonzero |
| b_sig | input | 53 | Divisor significand, leading bit explicit, nonzero |
| busy | output | 1 | Division in progress |
| done | output | 1 | One-cycle result strobe |
| quo | output | 54 | Quotient, unit bit at 53 |
| sticky | output | 1 | Nonzero final remainder |
| a_lz | output | 6 | Left shift applied to the dividend |
| b_lz | output | 6 | Left shift applied to the divisor |
| q_adj | output | 1 | Dividend was doubled (quotient exponent minus one) |

## Verification
Two functions can fall in the same cycle. The completion strobe of one division can coincide with acceptance of the next, because the unit returns to idle in the very cycle it raises `done`. The bench provokes this by holding `start` high with new operands in exactly the cycle where `done` is seen. It checks the finishing quotient and sticky in that cycle, then checks that the second division arrives 11 cycles later with its own exact result. A second stimulus raises `start` with different operands in the middle of a division and checks that the running result and its latency do not change.

// File: rtl/nr_div_pkg.sv
package nr_div_pkg;

    typedef enum logic [2:0] {
        S_IDLE,
        S_NORM,
        S_SEED,
        S_MUL_T,
        S_MUL_X,
        S_QMUL,
        S_REM,
        S_FIX
    } dstate_e;

    // Reciprocal of the midpoint of seed interval idx, scaled by 2^frac_w.
    function automatic longint unsigned seed_value(int unsigned idx,
                                                   int unsigned idx_w,
                                                   int unsigned frac_w);
        longint unsigned den;
        longint unsigned num;
        den = (64'd1 << (idx_w + 1)) + 64'(2 * idx) + 64'd1;
        num = 64'd1 << (frac_w + idx_w + 1);
        return num / den;
    endfunction

    function automatic int unsigned max2(int unsigned x, int unsigned y);
        return (x > y) ? x : y;
    endfunction

endpackage

// File: rtl/nr_div_norm.sv
module nr_div_norm #(
    parameter int unsigned W    = 53,
    parameter int unsigned LZ_W = 6
) (
    input  logic [W-1:0]    raw,
    output logic [W-1:0]    norm,
    output logic [LZ_W-1:0] lz
);

    always_comb begin
        lz = '0;
        for (int i = 0; i < W; i++) begin
            if (raw[i]) begin
                lz = LZ_W'(W - 1 - i);
            end
        end
        norm = raw << lz;
    end

endmodule

// File: rtl/nr_div_seed.sv
module nr_div_seed #(
    parameter int unsigned IDX_W  = 8,
    parameter int unsigned SEED_F = 12
) (
    input  logic [IDX_W-1:0] idx,
    output logic [SEED_F:0]  seed
);

    localparam int unsigned ENTRIES = 1 << IDX_W;

    logic [SEED_F:0] tbl [ENTRIES];

    for (genvar g = 0; g < ENTRIES; g++) begin : g_ent
        assign tbl[g] = (SEED_F + 1)'(nr_div_pkg::seed_value(g, IDX_W, SEED_F));
    end

    assign seed = tbl[idx];

endmodule

// File: rtl/nr_sig_div.sv
module nr_sig_div #(
    parameter int unsigned SIG_W    = 53,
    parameter int unsigned RECIP_F  = 56,
    parameter int unsigned SEED_IDX = 8,
    parameter int unsigned SEED_F   = 12,
    parameter int unsigned NR_STEPS = 3
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     start,
    input  logic [SIG_W-1:0]         a_sig,
    input  logic [SIG_W-1:0]         b_sig,
    output logic                     busy,
    output logic                     done,
    output logic [RECIP_F-3:0]       quo,
    output logic                     sticky,
    output logic [$clog2(SIG_W)-1:0] a_lz,
    output logic [$clog2(SIG_W)-1:0] b_lz,
    output logic                     q_adj
);
    import nr_div_pkg::*;

    localparam int unsigned FW   = SIG_W - 1;          // operand fraction bits
    localparam int unsigned XW   = RECIP_F + 1;        // reciprocal width
    localparam int unsigned TW   = RECIP_F + 2;        // B*x width
    localparam int unsigned QF   = RECIP_F - 3;        // quotient fraction bits
    localparam int unsigned QW   = QF + 1;
    localparam int unsigned AW   = SIG_W + 1;          // dividend after doubling
    localparam int unsigned MW   = max2(AW, XW);
    localparam int unsigned PW   = 2 * MW;
    localparam int unsigned RW   = AW + QF + 1;        // signed remainder
    localparam int unsigned LZ_W = $clog2(SIG_W);
    localparam int unsigned CW   = $clog2(NR_STEPS + 1);
    localparam int unsigned QSH  = FW + RECIP_F - QF;

    typedef struct packed {
        dstate_e         st;
        logic [CW-1:0]   step;
        logic [AW-1:0]   a_w;
        logic [SIG_W-1:0] b_w;
        logic [XW-1:0]   x;
        logic [TW-1:0]   t;
        logic [QW-1:0]   r;
        logic [RW-1:0]   rem;
        logic [LZ_W-1:0] a_lz;
        logic [LZ_W-1:0] b_lz;
        logic            q_adj;
        logic [QW-1:0]   quo;
        logic            sticky;
        logic            done;
    } dv_t;

    dv_t st_d, st_q;

    logic [SIG_W-1:0] a_norm, b_norm;
    logic [LZ_W-1:0]  a_lz_c, b_lz_c;
    logic [SEED_F:0]  seed;
    logic [XW-1:0]    e_val;
    logic [MW-1:0]    op1, op2;
    logic [PW-1:0]    prod;
    logic [RW-1:0]    rem_less_b;
    logic             fix_phase;
    logic [RW-1:0]    rem_now;
    logic             sink_unused;

    nr_div_norm #(.W(SIG_W), .LZ_W(LZ_W)) u_norm_a (
        .raw  (st_q.a_w[SIG_W-1:0]),
        .norm (a_norm),
        .lz   (a_lz_c)
    );

    nr_div_norm #(.W(SIG_W), .LZ_W(LZ_W)) u_norm_b (
        .raw  (st_q.b_w),
        .norm (b_norm),
        .lz   (b_lz_c)
    );

    nr_div_seed #(.IDX_W(SEED_IDX), .SEED_F(SEED_F)) u_seed (
        .idx  (st_q.b_w[SIG_W-2 -: SEED_IDX]),
        .seed (seed)
    );

    // One's complement of B*x: 2 - t - ulp, never above 2 - B*x.
    assign e_val = ~st_q.t[XW-1:0];

    // Single shared multiplier, operands chosen by phase.
    always_comb begin
        unique case (st_q.st)
            S_MUL_T: begin op1 = MW'(st_q.b_w); op2 = MW'(st_q.x); end
            S_MUL_X: begin op1 = MW'(st_q.x);   op2 = MW'(e_val);  end
            S_QMUL:  begin op1 = MW'(st_q.a_w); op2 = MW'(st_q.x); end
            default: begin op1 = MW'(st_q.r);   op2 = MW'(st_q.b_w); end
        endcase
    end

    assign prod       = PW'(op1) * PW'(op2);
    assign rem_less_b = st_q.rem - RW'(st_q.b_w);

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        unique case (st_q.st)
            S_IDLE: begin
                if (start) begin
                    st_d.a_w = AW'(a_sig);
                    st_d.b_w = b_sig;
                    st_d.st  = S_NORM;
                end
            end
            S_NORM: begin
                st_d.a_w  = AW'(a_norm);
                st_d.b_w  = b_norm;
                st_d.a_lz = a_lz_c;
                st_d.b_lz = b_lz_c;
                st_d.st   = S_SEED;
            end
            S_SEED: begin
                st_d.q_adj = st_q.a_w[SIG_W-1:0] < st_q.b_w;
                st_d.a_w   = st_d.q_adj ? {st_q.a_w[SIG_W-1:0], 1'b0}
                                        : AW'(st_q.a_w[SIG_W-1:0]);
                st_d.x     = XW'(seed) << (RECIP_F - SEED_F);
                st_d.step  = '0;
                st_d.st    = S_MUL_T;
            end
            S_MUL_T: begin
                st_d.t  = prod[FW +: TW];
                st_d.st = S_MUL_X;
            end
            S_MUL_X: begin
                st_d.x = prod[RECIP_F +: XW];
                if (st_q.step == CW'(NR_STEPS - 1)) begin
                    st_d.st = S_QMUL;
                end else begin
                    st_d.step = st_q.step + 1'b1;
                    st_d.st   = S_MUL_T;
                end
            end
            S_QMUL: begin
                st_d.r  = prod[QSH +: QW];
                st_d.st = S_REM;
            end
            S_REM: begin
                st_d.rem = {1'b0, st_q.a_w, {QF{1'b0}}} - prod[RW-1:0];
                st_d.st  = S_FIX;
            end
            S_FIX: begin
                if (st_q.rem >= RW'(st_q.b_w)) begin
                    st_d.quo    = st_q.r + 1'b1;
                    st_d.sticky = |rem_less_b;
                end else begin
                    st_d.quo    = st_q.r;
                    st_d.sticky = |st_q.rem;
                end
                st_d.done = 1'b1;
                st_d.st   = S_IDLE;
            end
            default: st_d.st = S_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign busy      = (st_q.st != S_IDLE);
    assign done      = st_q.done;
    assign quo       = st_q.quo;
    assign sticky    = st_q.sticky;
    assign a_lz      = st_q.a_lz;
    assign b_lz      = st_q.b_lz;
    assign q_adj     = st_q.q_adj;
    assign fix_phase = (st_q.st == S_FIX);
    assign rem_now   = st_q.rem;

    assign sink_unused = ^{prod, st_q.t, fix_phase, rem_now};

endmodule

// File: rtl/nr_sig_div_chk.sv
module nr_sig_div_chk #(
    parameter int unsigned QW = 54,
    parameter int unsigned RW = 108
) (
    input logic          clk,
    input logic          rst_n,
    input logic          start,
    input logic          busy,
    input logic          done,
    input logic [QW-1:0] quo,
    input logic          fix_phase,
    input logic [RW-1:0] rem_now
);

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R1

    AST_IDLE_AT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy); // R1

    AST_START_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> busy); // R1

    AST_QUO_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> $stable(quo)); // R5

    AST_QUO_UNIT_BIT: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> quo[QW-1]); // R5

    AST_REM_NONNEG: assert property (@(posedge clk) disable iff (!rst_n)
        fix_phase |-> !rem_now[RW-1]); // R9

endmodule

bind nr_sig_div nr_sig_div_chk #(.QW(QW), .RW(RW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .busy      (busy),
    .done      (done),
    .quo       (quo),
    .fix_phase (fix_phase),
    .rem_now   (rem_now)
);

// File: tb/nr_sig_div_test.sv
module nr_sig_div_test;

    localparam int unsigned SW  = 53;
    localparam int unsigned RF  = 56;
    localparam int unsigned NRS = 3;
    localparam int unsigned QW  = RF - 2;
    localparam int unsigned QF  = RF - 3;
    localparam int unsigned LZW = 6;
    localparam int          LAT = 5 + 2 * NRS;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic           rst_n;
    logic           start;
    logic [SW-1:0]  a_in, b_in;
    logic           busy, done, sticky, q_adj;
    logic [QW-1:0]  quo;
    logic [LZW-1:0] a_lz, b_lz;

    nr_sig_div #(.SIG_W(SW), .RECIP_F(RF), .SEED_IDX(8), .SEED_F(12), .NR_STEPS(NRS)) uut (
        .clk(clk), .rst_n(rst_n), .start(start), .a_sig(a_in), .b_sig(b_in),
        .busy(busy), .done(done), .quo(quo), .sticky(sticky),
        .a_lz(a_lz), .b_lz(b_lz), .q_adj(q_adj)
    );

    int checks = 0;
    int errors = 0;
    bit finished = 0;
    logic [63:0] rng = 64'h9E3779B97F4A7C15;

    task automatic check(input bit ok, input string req, input logic [127:0] act,
                         input logic [127:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic next_rnd(output logic [63:0] v);
        rng = rng ^ (rng << 13);
        rng = rng ^ (rng >> 7);
        rng = rng ^ (rng << 17);
        v = rng;
    endtask

    task automatic ref_div(input logic [SW-1:0] a, input logic [SW-1:0] b,
                           output logic [QW-1:0] q, output logic st,
                           output logic [LZW-1:0] alz, output logic [LZW-1:0] blz,
                           output logic adj);
        logic [127:0] an, bn, num, qq, rr;
        alz = '0;
        blz = '0;
        for (int i = 0; i < SW; i++) begin
            if (a[i]) alz = LZW'(SW - 1 - i);
            if (b[i]) blz = LZW'(SW - 1 - i);
        end
        an  = 128'(a) << alz;
        bn  = 128'(b) << blz;
        adj = (an < bn);
        if (adj) an = an << 1;
        num = an << QF;
        qq  = num / bn;
        rr  = num % bn;
        q   = qq[QW-1:0];
        st  = (rr != 0);
    endtask

    // Drive start for one cycle; returns at the first falling edge after the accepting edge.
    task automatic launch(input logic [SW-1:0] a, input logic [SW-1:0] b);
        @(negedge clk);
        a_in  = a;
        b_in  = b;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic wait_done(output int lat);
        lat = 0;
        while (!done && lat < 64) begin
            @(negedge clk);
            lat++;
        end
    endtask

    task automatic check_result(input logic [SW-1:0] a, input logic [SW-1:0] b,
                                input string tag);
        logic [QW-1:0]  eq;
        logic           es, eadj;
        logic [LZW-1:0] ealz, eblz;
        ref_div(a, b, eq, es, ealz, eblz, eadj);
        check(done == 1'b1, {"R1 done strobe ", tag}, 128'(done), 128'd1);
        check(quo == eq, {"R5 quotient ", tag}, 128'(quo), 128'(eq));
        check(sticky == es, {"R6 sticky ", tag}, 128'(sticky), 128'(es));
        check(a_lz == ealz && b_lz == eblz, {"R3 shift counts ", tag},
              {a_lz, b_lz}, {ealz, eblz});
        check(q_adj == eadj, {"R4 halving flag ", tag}, 128'(q_adj), 128'(eadj));
    endtask

    task automatic run_op(input logic [SW-1:0] a, input logic [SW-1:0] b,
                          input string tag);
        int lat;
        launch(a, b);
        check(busy == 1'b1, {"R1 busy after accept ", tag}, 128'(busy), 128'd1);
        wait_done(lat);
        check(lat == LAT, {"R1 latency ", tag}, 128'(lat), 128'(LAT));
        check(busy == 1'b0, {"R1 idle at done ", tag}, 128'(busy), 128'd0);
        check_result(a, b, tag);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL R1 watchdog actual=hung expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [63:0]   r1, r2;
        logic [SW-1:0] ones;
        logic [SW-1:0] one;
        int            lat;
        ones  = '1;
        one   = SW'(1) << (SW - 1);
        rst_n = 1'b0;
        start = 1'b0;
        a_in  = '0;
        b_in  = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R11 reset state
        check(busy == 1'b0, "R11 busy after reset", 128'(busy), 128'd0);
        check(done == 1'b0, "R11 done after reset", 128'(done), 128'd0);
        check(quo == '0, "R11 quotient after reset", 128'(quo), 128'd0);
        check(sticky == 1'b0, "R11 sticky after reset", 128'(sticky), 128'd0);

        // R8 equal operands give exactly 1.0
        run_op(one, one, "R8 one/one");
        check(quo == (QW'(1) << QF) && !sticky && !q_adj, "R8 exact unity",
              {quo, sticky, q_adj}, {QW'(1) << QF, 2'b00});
        run_op(ones, ones, "R8 ones/ones");
        check(quo == (QW'(1) << QF) && !sticky, "R8 exact unity ones",
              {quo, sticky}, {QW'(1) << QF, 1'b0});
        run_op(SW'(12345), SW'(12345), "R8 subnormal pair");
        check(quo == (QW'(1) << QF) && !sticky, "R8 exact unity subnormal",
              {quo, sticky}, {QW'(1) << QF, 1'b0});

        // R7 divisor all ones
        run_op(ones, ones - 1'b1, "R7 near-unity");
        run_op(one, ones, "R7 one/allones");
        run_op(SW'(1), ones, "R7 tiny/allones");
        for (int k = 0; k < 16; k++) begin
            next_rnd(r1);
            run_op(SW'(r1) | one, ones, "R7 random/allones");
        end

        // R3 subnormal operands
        run_op(SW'(1), SW'(3), "R3 tiny operands");
        run_op(SW'(5), one, "R3 subnormal dividend");
        run_op(ones, SW'(7), "R3 subnormal divisor");
        run_op(one, one | SW'(1), "R4 just below one");

        // Sweep over every seed interval, with random low bits and with
        // the top of each interval (largest reciprocal error). R9 R5 R6
        for (int idx = 0; idx < 256; idx++) begin
            next_rnd(r1);
            next_rnd(r2);
            run_op(SW'(r2) | one, one | (SW'(idx) << 44) | SW'(r1[43:0]),
                   "R9 seed sweep");
            run_op(SW'(r1) | one, one | (SW'(idx) << 44) | SW'(44'hFFFFFFFFFFF),
                   "R9 interval top");
            run_op(SW'(r2 >> (idx % 50)), SW'(r1 >> (idx % 47)) | SW'(1),
                   "R3 random scaled");
        end

        // R2 start and operand changes while busy are ignored
        launch(one | SW'(77), SW'(3) << 50);
        repeat (3) @(negedge clk);
        a_in  = SW'(9);
        b_in  = ones;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        lat = 4;
        while (!done && lat < 64) begin
            @(negedge clk);
            lat++;
        end
        check(lat == LAT, "R2 latency unchanged", 128'(lat), 128'(LAT));
        check_result(one | SW'(77), SW'(3) << 50, "R2 in-flight result");
        @(negedge clk);
        check(busy == 1'b0, "R2 no extra division", 128'(busy), 128'd0);

        // R10 new start in the cycle of done
        launch(ones, one | SW'(5));
        wait_done(lat);
        check_result(ones, one | SW'(5), "R10 first result");
        a_in  = SW'(3);
        b_in  = SW'(7) << 20;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check(busy == 1'b1, "R10 accepted at done", 128'(busy), 128'd1);
        wait_done(lat);
        check(lat == LAT, "R10 second latency", 128'(lat), 128'(LAT));
        check_result(SW'(3), SW'(7) << 20, "R10 second result");

        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule